// File: doc/BRIEF.md
# Multi-Select Static Memory Model

This block is a clocked, synthesizable behavioural model of a small static memory: 128 words of 8 bits, reached through a 7-bit address. It has one data bus shared by both directions, two active-low strobes (read and write) and five chip selects. Two of the selects are active high and three are active low. A system decodes its address space onto the selects, so the memory only answers when every select is at its active level.

A real tri-state bus is shown here as two signals: an output-enable flag and an output word, plus a separate input word. The bench can then see exactly when the bus is released. Read access time is given as a number of clock edges. When the read address changes, the word already on the bus stays driven until the new word is ready. Internally the array is split into rows and columns. The upper address bits pick a row and the lower bits pick a column.

Top module: `multiSelSram`

## Requirements
- R1: After reset `busOe` is low and `busOut` is zero.
- R2: The memory is selected only when both bits of `selHi` are 1 and all three bits of `selLo` are 0.
- R3: If any select bit is at its inactive level, the bus is released and no write takes place, whatever the strobes are.
- R4: A read (`rdStrobeN` low, `wrStrobeN` high, selected) drives the word stored at `memAddr` onto `busOut` with `busOe` high.
- R5: A write (`rdStrobeN` high, `wrStrobeN` low, selected) stores `busIn` at `memAddr` on the clock edge, and the bus stays released.
- R6: Standby (both strobes high, selected) releases the bus and leaves the stored data unchanged.
- R7: `busOe` first rises after the ACCESS_LAT-th rising edge that samples an uninterrupted read, counting the edge where the read begins as the first.
- R8: With both strobes low while selected, `illegalReq` is high, the bus is released and no write takes place.
- R9: If the address changes during a read, the previously driven word stays on `busOut` until ACCESS_LAT edges after the change, then the new word appears.
- R10: The bus is released in the same cycle that `rdStrobeN` rises or the memory is deselected.
- R11: `illegalReq` is low whenever the memory is not selected.
- R12: Address bits [6:3] select one of 16 rows and bits [2:0] one of 8 columns. All 128 addresses hold distinct words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rstN | input | 1 | Active-low reset of the control state |
| memAddr | input | 7 | Word address |
| rdStrobeN | input | 1 | Read strobe, active low |
| wrStrobeN | input | 1 | Write strobe, active low |
| selHi | input | 2 | Selects that must be high |
| selLo | input | 3 | Selects that must be low |
| busIn | input | 8 | Data arriving from the bus |
| busOe | output | 1 | Bus driven by the memory |
| busOut | output | 8 | Data driven onto the bus, zero when released |
| illegalReq | output | 1 | Both strobes low while selected |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an address change and the end of an access wait. The second is a strobe conflict and a select drop. The bench changes the address while a read is still being served, sometimes on every cycle. It also lowers both strobes, and drops each select in turn during write and read attempts. A behavioural reference model predicts the enable, the data and the conflict flag on every clock. After the disturbances, the bench reads all locations back, which shows whether any of these stimuli let a write through.

// File: rtl/sramPkg.sv
package sramPkg;
  // Strobes from the control to the storage datapath
  typedef struct packed {
    logic wrEn;   // store the bus word at the current address
    logic capEn;  // latch the addressed word for driving
  } sramStrobe_t;
endpackage

// File: rtl/sramCtrl.sv
module sramCtrl
  import sramPkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int ACCESS_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [1:0]        selHi,
  input  logic [2:0]        selLo,
  output sramStrobe_t       strobe,
  output logic              busOe,
  output logic              illegalReq
);
  localparam int CNT_W = $clog2(ACCESS_LAT + 1);
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(ACCESS_LAT);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic selected, readReq, writeReq, fresh;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic [ADDR_W-1:0] prevAddr;
  logic prevRead, valid;

  always_comb begin
    selected   = (&selHi) & ~(|selLo);
    readReq    = selected & ~rdN & wrN;
    writeReq   = selected & rdN & ~wrN;
    illegalReq = selected & ~rdN & ~wrN;
    fresh      = readReq & (~prevRead | (addr != prevAddr));
    if (!readReq)        nextCnt = '0;
    else if (fresh)      nextCnt = ONE_C;
    else if (cnt < LAT_C) nextCnt = cnt + ONE_C;
    else                 nextCnt = cnt;
    strobe.wrEn  = writeReq;
    strobe.capEn = readReq & (nextCnt == LAT_C);
    busOe        = readReq & valid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      prevAddr <= '0;
      prevRead <= 1'b0;
      valid    <= 1'b0;
    end else begin
      cnt      <= nextCnt;
      prevAddr <= addr;
      prevRead <= readReq;
      valid    <= readReq & (valid | strobe.capEn);
    end
  end
endmodule

// File: rtl/sramDatapath.sv
module sramDatapath
  import sramPkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 3,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  sramStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] heldWord
);
  localparam int ROWS = 1 << ROW_BITS;
  localparam int COLS = 1 << COL_BITS;

  logic [ROW_BITS-1:0] rowIdx;
  logic [COL_BITS-1:0] colIdx;
  logic [ROWS-1:0] rowSel;
  logic [COLS-1:0] colSel;
  logic [DATA_W-1:0] cells [ROWS][COLS];
  logic [DATA_W-1:0] rowData [COLS];

  assign rowIdx = addr[ADDR_W-1:COL_BITS];
  assign colIdx = addr[COL_BITS-1:0];

  // separate one-hot row and column decoders
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign rowSel[r] = (rowIdx == ROW_BITS'(r));
  end
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign colSel[c]  = (colIdx == COL_BITS'(c));
    assign rowData[c] = cells[rowIdx][c];
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (strobe.wrEn && rowSel[r] && colSel[c]) cells[r][c] <= wrData;
    if (strobe.capEn) heldWord <= rowData[colIdx];
  end
endmodule

// File: rtl/multiSelSram.sv
module multiSelSram
  import sramPkg::*;
#(
  parameter int ROW_BITS   = 4,
  parameter int COL_BITS   = 3,
  parameter int DATA_W     = 8,
  parameter int ACCESS_LAT = 2,
  localparam int ADDR_W    = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              rdStrobeN,
  input  logic              wrStrobeN,
  input  logic [1:0]        selHi,
  input  logic [2:0]        selLo,
  input  logic [DATA_W-1:0] busIn,
  output logic              busOe,
  output logic [DATA_W-1:0] busOut,
  output logic              illegalReq
);
  sramStrobe_t strobe;
  logic [DATA_W-1:0] heldWord;

  sramCtrl #(.ADDR_W(ADDR_W), .ACCESS_LAT(ACCESS_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(memAddr), .rdN(rdStrobeN), .wrN(wrStrobeN),
    .selHi(selHi), .selLo(selLo), .strobe(strobe), .busOe(busOe),
    .illegalReq(illegalReq)
  );

  sramDatapath #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .addr(memAddr), .strobe(strobe), .wrData(busIn),
    .heldWord(heldWord)
  );

  assign busOut = busOe ? heldWord : '0;
endmodule

// File: rtl/sramChecker.sv
module sramChecker #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              rdStrobeN,
  input logic              wrStrobeN,
  input logic [1:0]        selHi,
  input logic [2:0]        selLo,
  input logic              busOe,
  input logic [DATA_W-1:0] busOut,
  input logic              illegalReq
);
  logic sel;
  assign sel = (&selHi) & ~(|selLo);

  a_r3_desel_release: assert property (@(posedge clk) disable iff (!rstN)
    !sel |-> !busOe);
  a_r5_write_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobeN && !wrStrobeN) |-> !busOe);
  a_r8_conflict_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    illegalReq |-> !busOe);
  a_r10_strobe_release: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobeN |-> !busOe);
  a_r11_flag_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    !sel |-> !illegalReq);
  a_r7_not_immediate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOe) |-> $past(!rdStrobeN && wrStrobeN));
  a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> (busOut == '0));
endmodule

bind multiSelSram sramChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .memAddr(memAddr), .rdStrobeN(rdStrobeN),
  .wrStrobeN(wrStrobeN), .selHi(selHi), .selLo(selLo), .busOe(busOe),
  .busOut(busOut), .illegalReq(illegalReq)
);

// File: tb/test_multiSelSram.sv
module test_multiSelSram;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic [6:0] memAddr = '0;
  logic rdStrobeN = 1'b1, wrStrobeN = 1'b1;
  logic [1:0] selHi = 2'b11;
  logic [2:0] selLo = 3'b000;
  logic [7:0] busIn = '0;
  logic busOe, illegalReq;
  logic [7:0] busOut;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  // reference model state
  int refMem [128];
  int refCnt = 0, refHeld = 0, refPrevAddr = 0;
  bit refValid = 0, refPrevRead = 0;

  multiSelSram #(.ACCESS_LAT(LAT)) i_multiSelSram (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .rdStrobeN(rdStrobeN),
    .wrStrobeN(wrStrobeN), .selHi(selHi), .selLo(selLo), .busIn(busIn),
    .busOe(busOe), .busOut(busOut), .illegalReq(illegalReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit isSel();
    return (selHi == 2'b11) && (selLo == 3'b000);
  endfunction

  function automatic int pat(int a);
    return (a * 37 + 5) & 8'hFF;
  endfunction

  // reference model update
  always @(posedge clk) begin
    if (!rstN) begin
      refCnt = 0; refValid = 0; refPrevRead = 0; refPrevAddr = 0;
    end else begin
      bit rd, wr;
      rd = isSel() && !rdStrobeN && wrStrobeN;
      wr = isSel() && rdStrobeN && !wrStrobeN;
      if (wr) refMem[memAddr] = busIn;
      if (!rd) begin
        refCnt = 0; refValid = 0;
      end else begin
        if (!refPrevRead || memAddr != refPrevAddr) refCnt = 1;
        else if (refCnt < LAT) refCnt++;
        if (refCnt == LAT) begin refHeld = refMem[memAddr]; refValid = 1; end
      end
      refPrevAddr = memAddr;
      refPrevRead = rd;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare outputs every cycle, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      bit rd, expOe;
      rd = isSel() && !rdStrobeN && wrStrobeN;
      expOe = rd && refValid;
      chk(tag, "busOe", busOe, expOe);
      chk(tag, "busOut", busOut, expOe ? refHeld : 0);
      chk(isSel() ? "R8" : "R11", "illegalReq", illegalReq,
          isSel() && !rdStrobeN && !wrStrobeN);
    end
  end

  task automatic drive(int a, bit rdn, bit wrn, logic [1:0] hi, logic [2:0] lo,
                       int d, int n);
    memAddr = 7'(a); rdStrobeN = rdn; wrStrobeN = wrn;
    selHi = hi; selLo = lo; busIn = 8'(d);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset busOe", busOe, 0);
    chk("R1", "reset busOut", busOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5 / R12: fill every location with a distinct word
    tag = "R5";
    for (int a = 0; a < 128; a++) drive(a, 1, 0, 2'b11, 3'b000, pat(a), 1);

    // R4 / R7 / R12: read every location back
    tag = "R4";
    for (int a = 0; a < 128; a++) begin
      drive(a, 0, 1, 2'b11, 3'b000, 0, LAT + 1);
      chk("R12", "readback", busOut, pat(a));
      drive(a, 1, 1, 2'b11, 3'b000, 0, 1);
    end

    // R7: enable appears exactly after LAT edges
    tag = "R7";
    drive(20, 0, 1, 2'b11, 3'b000, 0, LAT - 1);
    chk("R7", "early enable", busOe, 0);
    drive(20, 0, 1, 2'b11, 3'b000, 0, 1);
    chk("R7", "enable on time", busOe, 1);

    // R10: release when read strobe rises
    tag = "R10";
    drive(20, 1, 1, 2'b11, 3'b000, 0, 1);
    chk("R10", "release on strobe", busOe, 0);

    // R2 / R3: drop each select in turn during write and read attempts
    tag = "R3";
    for (int s = 0; s < 5; s++) begin
      logic [1:0] hi = 2'b11;
      logic [2:0] lo = 3'b000;
      if (s < 2) hi[s] = 1'b0; else lo[s-2] = 1'b1;
      drive(40 + s, 1, 0, hi, lo, 8'hA5, 2);
      drive(40 + s, 0, 1, hi, lo, 0, LAT + 1);
      chk("R2", "not selected", busOe, 0);
      drive(40 + s, 0, 0, hi, lo, 0, 1);
      chk("R11", "no flag when deselected", illegalReq, 0);
    end

    // R8: conflicting strobes, no write
    tag = "R8";
    drive(50, 0, 0, 2'b11, 3'b000, 8'h3C, 2);
    chk("R8", "conflict flag", illegalReq, 1);

    // R6: standby
    tag = "R6";
    drive(51, 1, 1, 2'b11, 3'b000, 8'h77, 3);

    // R10: deselect mid-read releases in the same cycle
    tag = "R10";
    drive(60, 0, 1, 2'b11, 3'b000, 0, LAT + 1);
    drive(60, 0, 1, 2'b11, 3'b100, 0, 1);
    chk("R10", "release on deselect", busOe, 0);

    // R9: address change during a read keeps the old word
    tag = "R9";
    drive(5, 0, 1, 2'b11, 3'b000, 0, LAT + 1);
    drive(9, 0, 1, 2'b11, 3'b000, 0, 1);
    chk("R9", "old word held", busOut, pat(5));
    drive(9, 0, 1, 2'b11, 3'b000, 0, LAT);
    chk("R9", "new word", busOut, pat(9));
    for (int a = 70; a < 80; a++) drive(a, 0, 1, 2'b11, 3'b000, 0, 1);
    chk("R9", "held through rapid changes", busOut, pat(9));
    drive(79, 0, 1, 2'b11, 3'b000, 0, LAT);
    drive(79, 1, 1, 2'b11, 3'b000, 0, 1);

    // readback after disturbances: nothing was overwritten
    tag = "R3";
    for (int a = 40; a < 52; a++) begin
      drive(a, 0, 1, 2'b11, 3'b000, 0, LAT + 1);
      chk(a == 50 ? "R8" : (a == 51 ? "R6" : "R3"), "unchanged", busOut, pat(a));
      drive(a, 1, 1, 2'b11, 3'b000, 0, 1);
    end

    finishRun();
  end
endmodule